// File: doc/BRIEF.md
# Paged Memory Chip-Select Decoder with Boot Swap

This block sits between an 8051-class microcontroller bus and a set of memories. It turns each bus cycle into one chip select for the target memory. The address is 16 bits, and the cycle is either an instruction fetch or a data read or write. The memories are:

- eight 16 KB main flash segments
- four 8 KB secondary segments
- a 2 KB SRAM
- a 256-byte control block
- an external peripheral window

The control block holds two registers that the MCU writes at run time, and these change the decode:

- **Space-mapping register.** Chooses whether main flash and secondary memory answer instruction fetches, data cycles, or both.
- **Page register.** Holds a two-bit page number plus two decode-control bits, *swap* and *unlock*.

After reset the MCU fetches from secondary segment 0 at address 0, and main flash sits in data space where it can be programmed. Firmware then adds main flash to fetch space. Setting swap next replaces the low boot segments with main flash segment 0, so execution continues into main flash at the next address. Moving secondary memory into data space, with unlock picking the half, makes it writable.

Top module: `paged_cs_decoder`

## Requirements
- R1: After reset the page register reads 00h and the mapping register reads 12h, and an instruction fetch at 0000h selects secondary segment 0.
- R2: With mapping bit 1 set, an instruction fetch in 0000h-7FFFh selects secondary segment addr[14:13]; a fetch at 8000h or above selects no secondary segment.
- R3: With swap clear, and main flash visible in the cycle's space (mapping bit 2 for fetches, bit 4 for data cycles), the decoder selects main segment 2*P + addr[15], where P is page bits [1:0].
- R4: Only mapping bits 4:1 are stored. Any write to the mapping register reads back ANDed with 1Eh.
- R5: When swap (page bit 7) is set and main flash is visible to fetches, a fetch selects:
  - segment 0 at 0000h-3FFFh;
  - segment 1 at 4000h-7FFFh;
  - segment 2*P + addr[14] at 8000h-FFFFh when P is nonzero;
  - nothing above 7FFFh when P is 0.
- R6: With mapping bit 3 set, a data cycle in C000h-FFFFh selects secondary segment 2*U + addr[13], where U is unlock (page bit 6).
- R7: In data cycles only, 0100h-01FFh selects the control block, 0800h-0FFFh selects the SRAM, and 1000h-10FFh selects the peripheral. These override any flash decode. Fetches never select them.
- R8: At most one select is active. With no strobe active, no select is active. A fetch strobe takes precedence over read and write strobes.
- R9: A data write to control offset E0h loads the page register (all 8 bits), and one to offset E2h loads the mapping register. The load happens at the next rising clock edge. Writes to other offsets change neither register.
- R10: Overlapping flash decodes resolve in this order: swapped fixed main segments first, then secondary memory, then paged main flash.
- R11: A data read of control offset E0h or E2h returns that register on rdata. Other offsets, and cycles that are not control-block reads, return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Bus address |
| ifetch | input | 1 | Instruction fetch strobe, active high |
| rd_stb | input | 1 | Data read strobe, active high |
| wr_stb | input | 1 | Data write strobe, active high |
| wdata | input | 8 | Write data for control registers |
| rdata | output | 8 | Control register read data |
| main_sel | output | 8 | One-hot main flash segment selects |
| sec_sel | output | 4 | One-hot secondary segment selects |
| sram_sel | output | 1 | SRAM select |
| ctl_sel | output | 1 | Control block select |
| periph_sel | output | 1 | External peripheral select |

## Verification
The bench walks through the boot sequence and aims at the places where decodes overlap:

- **Fetch from low memory after fetch mapping 06h.** If paged flash outranked secondary memory, the boot code would be cut off, and the fetch would show a main select instead of secondary segment 0.
- **Fetch at 4000h with swap set.** A wrong priority selects secondary segment 2 instead of main segment 1.
- **Page 0 above 7FFFh with swap set.** This must stay unselected.
- **Unlock toggling.** The bench checks that unlock moves which secondary half appears in upper data space.
- **Control-block precedence.** The bench checks that the control, SRAM and peripheral windows override data-space flash.
- **Stray writes.** Writes to unused control offsets must leave both registers intact. An offset decode that is too loose shows up as a corrupted readback.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int N_MAIN = 8;
  localparam int N_SEC  = 4;

  localparam logic [ADDR_W-1:0] CTL_BASE  = 16'h0100;
  localparam int                CTL_SPAN  = 8;
  localparam logic [ADDR_W-1:0] SRAM_BASE = 16'h0800;
  localparam int                SRAM_SPAN = 11;
  localparam logic [ADDR_W-1:0] PER_BASE  = 16'h1000;
  localparam int                PER_SPAN  = 8;

  localparam logic [7:0] PAGE_OFS  = 8'hE0;
  localparam logic [7:0] MAP_OFS   = 8'hE2;
  localparam logic [DATA_W-1:0] MAP_RESET = 8'h12;
  localparam logic [DATA_W-1:0] MAP_MASK  = 8'h1E;

  localparam int PG_SWAP   = 7;
  localparam int PG_UNLOCK = 6;
  localparam int MP_SEC_PROG  = 1;
  localparam int MP_MAIN_PROG = 2;
  localparam int MP_SEC_DATA  = 3;
  localparam int MP_MAIN_DATA = 4;

  typedef enum logic [1:0] {
    SP_IDLE = 2'b00,
    SP_PROG = 2'b01,
    SP_DATA = 2'b10
  } space_e;
endpackage

// File: rtl/csd_regs.sv
module csd_regs
  import csd_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         page_we,
  input  logic         map_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] page_q,
  output logic [W-1:0] map_q
);
  logic [1:0]   rst_sync;
  logic         rst_int_n;
  logic [W-1:0] page_d;
  logic [W-1:0] map_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  always_comb begin
    page_d = page_q;
    map_d  = map_q;
    if (page_we) page_d = wdata;
    if (map_we)  map_d  = wdata & MAP_MASK;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      page_q <= '0;
      map_q  <= MAP_RESET;
    end else begin
      if (page_we) page_q <= page_d;
      if (map_we)  map_q  <= map_d;
    end
  end

  AST_MAP_LOAD: assert property (@(posedge clk) disable iff (!rst_int_n)
    map_we |=> map_q == ($past(wdata) & MAP_MASK)); // R4
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !page_we |=> $stable(page_q)); // R9
  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !map_we |=> $stable(map_q)); // R9
endmodule

// File: rtl/csd_region.sv
module csd_region
  import csd_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  space_e        space,
  output logic          ctl_hit,
  output logic          sram_hit,
  output logic          per_hit
);
  logic is_data;
  assign is_data  = (space == SP_DATA);
  assign ctl_hit  = is_data && (addr[AW-1:CTL_SPAN]  == CTL_BASE[AW-1:CTL_SPAN]);
  assign sram_hit = is_data && (addr[AW-1:SRAM_SPAN] == SRAM_BASE[AW-1:SRAM_SPAN]);
  assign per_hit  = is_data && (addr[AW-1:PER_SPAN]  == PER_BASE[AW-1:PER_SPAN]);
endmodule

// File: rtl/csd_main_map.sv
module csd_main_map
  import csd_pkg::*;
#(
  parameter int NM    = N_MAIN,
  localparam int IDX_W = $clog2(NM),
  localparam int PG_W  = IDX_W - 1
) (
  input  logic [1:0]      addr_hi,   // {a15, a14}
  input  space_e          space,
  input  logic            swap,
  input  logic [PG_W-1:0] page_idx,
  input  logic            vis_prog,
  input  logic            vis_data,
  output logic [NM-1:0]   common_sel,
  output logic [NM-1:0]   paged_sel
);
  logic             visible;
  logic             swapped;
  logic             common_hit;
  logic             paged_hit;
  logic [IDX_W-1:0] common_idx;
  logic [IDX_W-1:0] paged_idx;

  always_comb begin
    visible    = ((space == SP_PROG) && vis_prog) || ((space == SP_DATA) && vis_data);
    swapped    = (space == SP_PROG) && swap;
    common_hit = visible && swapped && !addr_hi[1];
    common_idx = {{(IDX_W-1){1'b0}}, addr_hi[0]};
    if (swapped) begin
      paged_hit = visible && addr_hi[1] && (page_idx != '0);
      paged_idx = {page_idx, addr_hi[0]};
    end else begin
      paged_hit = visible;
      paged_idx = {page_idx, addr_hi[1]};
    end
  end

  for (genvar i = 0; i < NM; i++) begin : g_seg
    assign common_sel[i] = common_hit && (common_idx == IDX_W'(i));
    assign paged_sel[i]  = paged_hit  && (paged_idx  == IDX_W'(i));
  end
endmodule

// File: rtl/csd_sec_map.sv
module csd_sec_map
  import csd_pkg::*;
#(
  parameter int NS    = N_SEC,
  localparam int IDX_W = $clog2(NS)
) (
  input  logic [2:0]    addr_hi,   // {a15, a14, a13}
  input  space_e        space,
  input  logic          unlock,
  input  logic          vis_prog,
  input  logic          vis_data,
  output logic [NS-1:0] sec_sel
);
  logic             hit;
  logic [IDX_W-1:0] idx;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    if ((space == SP_PROG) && vis_prog && !addr_hi[2]) begin
      hit = 1'b1;
      idx = IDX_W'(addr_hi[1:0]);
    end else if ((space == SP_DATA) && vis_data && (addr_hi[2:1] == 2'b11)) begin
      hit = 1'b1;
      idx = IDX_W'({unlock, addr_hi[0]});
    end
  end

  for (genvar j = 0; j < NS; j++) begin : g_sec
    assign sec_sel[j] = hit && (idx == IDX_W'(j));
  end
endmodule

// File: rtl/paged_cs_decoder.sv
module paged_cs_decoder
  import csd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NM = N_MAIN,
  parameter int NS = N_SEC,
  localparam int PG_W = $clog2(NM) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ifetch,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [NM-1:0] main_sel,
  output logic [NS-1:0] sec_sel,
  output logic          sram_sel,
  output logic          ctl_sel,
  output logic          periph_sel
);
  space_e        space;
  logic [DW-1:0] page_q;
  logic [DW-1:0] map_q;
  logic          page_we;
  logic          map_we;
  logic          ctl_hit;
  logic          sram_hit;
  logic          per_hit;
  logic [NM-1:0] common_sel;
  logic [NM-1:0] paged_sel;
  logic [NS-1:0] sec_raw;
  logic          aux_any;
  logic          common_any;
  logic          sec_any;

  // fetch strobe dominates data strobes
  always_comb begin
    if (ifetch)               space = SP_PROG;
    else if (rd_stb || wr_stb) space = SP_DATA;
    else                      space = SP_IDLE;
  end

  csd_region #(.AW(AW)) u_region (
    .addr    (addr),
    .space   (space),
    .ctl_hit (ctl_hit),
    .sram_hit(sram_hit),
    .per_hit (per_hit)
  );

  assign page_we = wr_stb && ctl_hit && (addr[7:0] == PAGE_OFS);
  assign map_we  = wr_stb && ctl_hit && (addr[7:0] == MAP_OFS);

  csd_regs #(.W(DW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .page_we(page_we),
    .map_we (map_we),
    .wdata  (wdata),
    .page_q (page_q),
    .map_q  (map_q)
  );

  csd_main_map #(.NM(NM)) u_main (
    .addr_hi   (addr[AW-1:AW-2]),
    .space     (space),
    .swap      (page_q[PG_SWAP]),
    .page_idx  (page_q[PG_W-1:0]),
    .vis_prog  (map_q[MP_MAIN_PROG]),
    .vis_data  (map_q[MP_MAIN_DATA]),
    .common_sel(common_sel),
    .paged_sel (paged_sel)
  );

  csd_sec_map #(.NS(NS)) u_sec (
    .addr_hi (addr[AW-1:AW-3]),
    .space   (space),
    .unlock  (page_q[PG_UNLOCK]),
    .vis_prog(map_q[MP_SEC_PROG]),
    .vis_data(map_q[MP_SEC_DATA]),
    .sec_sel (sec_raw)
  );

  // priority resolution: aux windows, swapped common main, secondary, paged main
  always_comb begin
    aux_any    = ctl_hit || sram_hit || per_hit;
    common_any = |common_sel;
    sec_any    = |sec_raw;
    ctl_sel    = ctl_hit;
    sram_sel   = sram_hit && !ctl_hit;
    periph_sel = per_hit && !ctl_hit && !sram_hit;
    if (aux_any)         main_sel = '0;
    else if (common_any) main_sel = common_sel;
    else if (sec_any)    main_sel = '0;
    else                 main_sel = paged_sel;
    sec_sel = (aux_any || common_any) ? '0 : sec_raw;
  end

  always_comb begin
    rdata = '0;
    if (rd_stb && ctl_hit) begin
      if (addr[7:0] == PAGE_OFS)     rdata = page_q;
      else if (addr[7:0] == MAP_OFS) rdata = map_q;
    end
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({main_sel, sec_sel, sram_sel, ctl_sel, periph_sel})); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(ifetch || rd_stb || wr_stb) |-> ({main_sel, sec_sel, sram_sel, ctl_sel, periph_sel} == '0)); // R8
  AST_SWAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ifetch && page_q[PG_SWAP] && map_q[MP_MAIN_PROG] && (addr < AW'(16'h4000)))
      |-> (main_sel == NM'(1))); // R5
  AST_FETCH_NO_AUX: assert property (@(posedge clk) disable iff (!rst_n)
    ifetch |-> !(ctl_sel || sram_sel || periph_sel)); // R7
endmodule

// File: tb/test_paged_cs_decoder.sv
module test_paged_cs_decoder;
  typedef struct packed {
    logic [7:0]  rdata;
    logic [14:0] sel;
    logic [7:0]  req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        ifetch = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  main_sel;
  logic [3:0]  sec_sel;
  logic        sram_sel, ctl_sel, periph_sel;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;
  logic [7:0] sh_page = 8'h00;
  logic [7:0] sh_map  = 8'h12;

  always #4 clk = ~clk;

  paged_cs_decoder i_paged_cs_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ifetch(ifetch), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata), .main_sel(main_sel),
    .sec_sel(sec_sel), .sram_sel(sram_sel), .ctl_sel(ctl_sel), .periph_sel(periph_sel)
  );

  // expected selects: [14] periph, [13] ctl, [12] sram, [11:8] sec, [7:0] main
  function automatic logic [14:0] model_sel(logic [15:0] a, logic f, logic r, logic w,
                                            logic [7:0] pg, logic [7:0] mp);
    logic [14:0] s;
    logic prog, data;
    int p;
    s = '0;
    prog = f;
    data = !f && (r || w);
    p = int'(pg[1:0]);
    if (data && a >= 16'h0100 && a <= 16'h01FF)      s[13] = 1'b1;
    else if (data && a >= 16'h0800 && a <= 16'h0FFF) s[12] = 1'b1;
    else if (data && a >= 16'h1000 && a <= 16'h10FF) s[14] = 1'b1;
    else if (prog && mp[2] && pg[7] && a < 16'h8000) s[(a >= 16'h4000) ? 1 : 0] = 1'b1;
    else if (prog && mp[1] && a < 16'h8000)          s[8 + int'(a[14:13])] = 1'b1;
    else if (data && mp[3] && a >= 16'hC000)         s[8 + 2*int'(pg[6]) + int'(a >= 16'hE000)] = 1'b1;
    else if (prog && mp[2] && pg[7]) begin
      if (p != 0) s[2*p + int'(a >= 16'hC000)] = 1'b1;
    end
    else if ((prog && mp[2]) || (data && mp[4]))     s[2*p + int'(a >= 16'h8000)] = 1'b1;
    return s;
  endfunction

  function automatic logic [7:0] model_rd(logic [15:0] a, logic f, logic r,
                                          logic [7:0] pg, logic [7:0] mp);
    if (f || !r) return 8'h00;
    if (a == 16'h01E0) return pg;
    if (a == 16'h01E2) return mp;
    return 8'h00;
  endfunction

  task automatic drive(input logic [15:0] a, input logic f, input logic r, input logic w,
                       input logic [7:0] d, input int req);
    exp_t it;
    @(negedge clk);
    addr = a; ifetch = f; rd_stb = r; wr_stb = w; wdata = d;
    it.sel   = model_sel(a, f, r, w, sh_page, sh_map);
    it.rdata = model_rd(a, f, r, sh_page, sh_map);
    it.req   = 8'(req);
    q.push_back(it);
    if (w && !f && a == 16'h01E0) sh_page = d;
    if (w && !f && a == 16'h01E2) sh_map  = d & 8'h1E;
  endtask

  // monitor: compare each cycle's outputs against the queued expectation
  always begin
    @(negedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t it;
      logic [14:0] act;
      it  = q.pop_front();
      act = {periph_sel, ctl_sel, sram_sel, sec_sel, main_sel};
      n_tests++;
      if (act !== it.sel || rdata !== it.rdata) begin
        n_fail++;
        $display("FAIL R%0d addr=%h sel act=%h exp=%h rdata act=%h exp=%h",
                 it.req, addr, act, it.sel, rdata, it.rdata);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R1: reset state
    drive(16'h01E0, 0, 1, 0, 0, 1);
    drive(16'h01E2, 0, 1, 0, 0, 1);
    drive(16'h0000, 1, 0, 0, 0, 1);
    // R2: secondary in fetch space
    drive(16'h2000, 1, 0, 0, 0, 2);
    drive(16'h4000, 1, 0, 0, 0, 2);
    drive(16'h7FFF, 1, 0, 0, 0, 2);
    drive(16'h8000, 1, 0, 0, 0, 2);
    // R3: paged main in data space
    drive(16'h4000, 0, 1, 0, 0, 3);
    drive(16'h8000, 0, 1, 0, 0, 3);
    drive(16'h01E0, 0, 0, 1, 8'h02, 9);   // R9 page write
    drive(16'h1234, 0, 1, 0, 0, 3);
    drive(16'hC000, 0, 1, 0, 0, 3);
    // R7: fixed windows
    drive(16'h0100, 0, 1, 0, 0, 7);
    drive(16'h0850, 0, 1, 0, 0, 7);
    drive(16'h10FF, 0, 0, 1, 8'h55, 7);
    drive(16'h1100, 0, 1, 0, 0, 7);
    drive(16'h0100, 1, 0, 0, 0, 7);
    // R8: idle and strobe precedence
    drive(16'h0000, 0, 0, 0, 0, 8);
    drive(16'h0800, 1, 1, 0, 0, 8);
    // R9 / R11: stray write ignored, readback
    drive(16'h01E4, 0, 0, 1, 8'hFF, 9);
    drive(16'h01E0, 0, 1, 0, 0, 9);
    drive(16'h01E2, 0, 1, 0, 0, 9);
    drive(16'h01E4, 0, 1, 0, 0, 11);
    drive(16'h01E0, 0, 0, 0, 0, 11);
    // R4 / R10: main added to fetch space, secondary keeps low region
    drive(16'h01E2, 0, 0, 1, 8'h06, 4);
    drive(16'h01E2, 0, 1, 0, 0, 4);
    drive(16'h8000, 1, 0, 0, 0, 4);
    drive(16'h0000, 1, 0, 0, 0, 10);
    drive(16'h4000, 0, 1, 0, 0, 4);
    // R5: swap
    drive(16'h01E0, 0, 0, 1, 8'h81, 5);
    drive(16'h0000, 1, 0, 0, 0, 5);
    drive(16'h3FFF, 1, 0, 0, 0, 5);
    drive(16'h4000, 1, 0, 0, 0, 10);
    drive(16'h8000, 1, 0, 0, 0, 5);
    drive(16'hC000, 1, 0, 0, 0, 5);
    drive(16'h01E0, 0, 0, 1, 8'h80, 5);
    drive(16'h9000, 1, 0, 0, 0, 5);
    // R6: secondary in data space with unlock
    drive(16'h01E2, 0, 0, 1, 8'h0C, 6);
    drive(16'hC000, 0, 1, 0, 0, 6);
    drive(16'hE000, 0, 1, 0, 0, 6);
    drive(16'h01E0, 0, 0, 1, 8'hC0, 6);
    drive(16'hC000, 0, 1, 0, 0, 6);
    drive(16'hFFFF, 0, 0, 1, 8'h00, 6);
    drive(16'h8000, 0, 1, 0, 0, 6);
    drive(16'h0000, 1, 0, 0, 0, 5);
    drive(16'h6000, 1, 0, 0, 0, 5);
    // R10: secondary beats paged main in data space
    drive(16'h01E2, 0, 0, 1, 8'h18, 10);
    drive(16'h01E0, 0, 0, 1, 8'h00, 10);
    drive(16'hC000, 0, 1, 0, 0, 10);
    drive(16'h8000, 0, 1, 0, 0, 10);
    // R4: unused mapping bits read zero
    drive(16'h01E2, 0, 0, 1, 8'hFF, 4);
    drive(16'h01E2, 0, 1, 0, 0, 4);
    drive(16'h0000, 0, 0, 0, 0, 8);
    repeat (3) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule